// File: doc/BRIEF.md
# Scatter-Gather Descriptor Chain Engine

This block walks a ring of buffer descriptors kept in word-addressed memory and hands the transfer each one describes to a separate data-mover. For every descriptor it reads the status word, the control word, the source, destination, length and next-pointer words. It then launches the transfer with a one-cycle start strobe and waits for the mover's done pulse. Finally it writes the status word back with the busy flag cleared. The walk continues along the next pointers until a descriptor asks for a halt, until a descriptor that software has not handed over turns up, or until software withdraws the enable.

Software drives the engine through five registers: an enable register, a halt register, a descriptor address register, a write-one-to-clear event register and a read-only status register. The descriptor address register always holds the address of the most recently completed descriptor. A later start resumes from that descriptor's next pointer. A completion strobe fires for each descriptor flagged as the end of a packet, so that an external packet counter can be driven from it.

Descriptor layout, as word offsets from the descriptor base: 0 control, 1 source, 2 destination, 3 length, 4 status, 5 device status, 6 identifier, 7 flags, 8 requested length, 9 next pointer. The engine touches only words 0 to 4 and 9.

Top module: `sgd_engine`

## Requirements
- R1: After reset the registers read as follows: enable (register 0, bit 31) is 0, halt (register 1, bit 31) is 1, descriptor address (register 2) is 0, events (register 3) is 0 and status (register 4, bit 31 = busy) is 0. No memory request and no transfer start is issued.
- R2: For each descriptor the engine presents the source (word 1), destination (word 2) and length (word 3) on the mover port together with a start strobe that lasts exactly one cycle.
- R3: Descriptors are processed in next-pointer (word 9) order. Each one is launched only after the previous one's done pulse.
- R4: After the mover's done pulse the engine writes the status word (offset 4) back with bit 31 (busy) cleared and every other bit unchanged.
- R5: A descriptor whose control word has bit 31 set (halt-after) is completed in full. The engine then sets the halt register bit and event bit 1 (chain end) and reads no further descriptor.
- R6: When a descriptor completes, the descriptor address register takes that descriptor's address.
- R7: Writing 1 to an event-register bit clears it. Writing 0 leaves it unchanged.
- R8: The status register's bit 31 reads 1 while a descriptor is in progress and 0 when the engine is idle.
- R9: After reset, or after software writes the descriptor address register, the next start fetches the descriptor at that address. Otherwise a start follows the next pointer of the last completed descriptor.
- R10: A descriptor whose status bit 31 is clear when it is fetched is not launched, and the engine returns to idle.
- R11: Writing 0 to the enable bit while it is set lets the current descriptor complete and launches no new one. Once the engine is idle, event bit 0 (disable acknowledge) is set.
- R12: The packet strobe pulses for one cycle, in the write-back cycle, exactly for descriptors whose control word has bit 30 (end of packet) set.
- R13: While the halt bit is set the engine issues no memory request, even with enable set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (with mem_req) |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid the cycle after a read request |
| xfer_start | output | 1 | One-cycle transfer launch strobe |
| xfer_src | output | 32 | Transfer source address |
| xfer_dst | output | 32 | Transfer destination address |
| xfer_len | output | 32 | Transfer length |
| xfer_done | input | 1 | Mover completion pulse |
| pkt_done | output | 1 | End-of-packet completion strobe |

## Verification
The engine is exercised with a four-entry ring that halts at its third descriptor. The ring mixes end-of-packet and plain descriptors, which separates halt-after handling from packet marking and shows that the walk order follows the next pointers. A resume from the last completed descriptor into one whose busy flag is already clear separates following the link from restarting at the written address, and shows that stale descriptors are refused. A disable that arrives during a long transfer shows that the current transfer finishes and that the acknowledge waits for idle. A final run from a freshly written address checks that the software write overrides the remembered position.

// File: rtl/sgd_pkg.sv
package sgd_pkg;

    localparam int unsigned WORD_W      = 32;

    // descriptor word offsets that the engine touches
    localparam int unsigned OFF_CTRL    = 0;
    localparam int unsigned OFF_SRC     = 1;
    localparam int unsigned OFF_DST     = 2;
    localparam int unsigned OFF_LEN     = 3;
    localparam int unsigned OFF_STAT    = 4;
    localparam int unsigned OFF_NEXT    = 9;
    localparam int unsigned FETCH_WORDS = 6;

    localparam int unsigned CTRL_HALT_BIT = 31;
    localparam int unsigned CTRL_EOP_BIT  = 30;
    localparam int unsigned STAT_BUSY_BIT = 31;

    // register selects
    localparam logic [2:0] RSEL_ENABLE = 3'd0;
    localparam logic [2:0] RSEL_HALT   = 3'd1;
    localparam logic [2:0] RSEL_DADDR  = 3'd2;
    localparam logic [2:0] RSEL_EVENT  = 3'd3;
    localparam logic [2:0] RSEL_STATUS = 3'd4;

    localparam int unsigned EVT_ACK_BIT = 0;
    localparam int unsigned EVT_END_BIT = 1;

    typedef enum logic [2:0] {
        W_IDLE,
        W_LINK_RQ,
        W_LINK_RX,
        W_FETCH_RQ,
        W_FETCH_RX,
        W_LAUNCH,
        W_WAIT,
        W_WB
    } walk_st_e;

    typedef struct packed {
        logic              halt_after;
        logic              eop;
        logic [WORD_W-1:0] src;
        logic [WORD_W-1:0] dst;
        logic [WORD_W-1:0] len;
        logic [WORD_W-1:0] stat;
    } desc_t;

    // fetch order: status first so a stale descriptor is refused early
    function automatic logic [3:0] fetch_off(input logic [2:0] k);
        case (k)
            3'd0:    fetch_off = 4'(OFF_STAT);
            3'd1:    fetch_off = 4'(OFF_CTRL);
            3'd2:    fetch_off = 4'(OFF_SRC);
            3'd3:    fetch_off = 4'(OFF_DST);
            3'd4:    fetch_off = 4'(OFF_LEN);
            default: fetch_off = 4'(OFF_NEXT);
        endcase
    endfunction

endpackage

// File: rtl/sgd_regs.sv
module sgd_regs
    import sgd_pkg::*;
#(
    parameter int unsigned AW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              run_en,
    output logic              halt,
    output logic [AW-1:0]     base_addr,
    output logic              have_last,
    input  logic              eng_busy,
    input  logic              done_evt,
    input  logic [AW-1:0]     done_addr,
    input  logic              chain_end
);

    logic          en_q, halt_q, have_last_q, ack_pend;
    logic [AW-1:0] daddr_q;
    logic [1:0]    evt_q;
    logic          ack_set;
    logic          wr_en, wr_halt, wr_daddr, wr_evt;
    logic [1:0]    evt_set, evt_clr;
    logic          unused_wdata;

    assign wr_en    = reg_we && (reg_addr == RSEL_ENABLE);
    assign wr_halt  = reg_we && (reg_addr == RSEL_HALT);
    assign wr_daddr = reg_we && (reg_addr == RSEL_DADDR);
    assign wr_evt   = reg_we && (reg_addr == RSEL_EVENT);
    assign ack_set  = ack_pend && !eng_busy;

    always_comb begin
        evt_set = '0;
        evt_set[EVT_ACK_BIT] = ack_set;
        evt_set[EVT_END_BIT] = chain_end;
        evt_clr = wr_evt ? reg_wdata[1:0] : 2'b00;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q        <= 1'b0;
            halt_q      <= 1'b1;
            daddr_q     <= '0;
            have_last_q <= 1'b0;
            evt_q       <= '0;
            ack_pend    <= 1'b0;
        end else begin
            if (ack_set)
                ack_pend <= 1'b0;
            if (wr_en) begin
                en_q <= reg_wdata[WORD_W-1];
                if (en_q && !reg_wdata[WORD_W-1])
                    ack_pend <= 1'b1;
            end
            // engine-set halt wins over a same-cycle software write
            if (chain_end)
                halt_q <= 1'b1;
            else if (wr_halt)
                halt_q <= reg_wdata[WORD_W-1];
            if (done_evt) begin
                daddr_q     <= done_addr;
                have_last_q <= 1'b1;
            end else if (wr_daddr) begin
                daddr_q     <= reg_wdata[AW-1:0];
                have_last_q <= 1'b0;
            end
            evt_q <= (evt_q & ~evt_clr) | evt_set;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RSEL_ENABLE: reg_rdata[WORD_W-1] = en_q;
            RSEL_HALT:   reg_rdata[WORD_W-1] = halt_q;
            RSEL_DADDR:  reg_rdata[AW-1:0]   = daddr_q;
            RSEL_EVENT:  reg_rdata[1:0]      = evt_q;
            RSEL_STATUS: reg_rdata[WORD_W-1] = eng_busy;
            default:     reg_rdata = '0;
        endcase
    end

    assign unused_wdata = ^reg_wdata;
    assign run_en    = en_q;
    assign halt      = halt_q;
    assign base_addr = daddr_q;
    assign have_last = have_last_q;

endmodule

// File: rtl/sgd_walker.sv
module sgd_walker
    import sgd_pkg::*;
#(
    parameter int unsigned AW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  logic              halt,
    input  logic [AW-1:0]     base_addr,
    input  logic              have_last,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              xfer_start,
    output logic [WORD_W-1:0] xfer_src,
    output logic [WORD_W-1:0] xfer_dst,
    output logic [WORD_W-1:0] xfer_len,
    input  logic              xfer_done,
    output logic              busy,
    output logic              done_evt,
    output logic [AW-1:0]     done_addr,
    output logic              chain_end,
    output logic              pkt_done
);

    localparam logic [2:0] K_LAST = 3'(FETCH_WORDS - 1);

    walk_st_e      st;
    logic [2:0]    k;
    logic [AW-1:0] cur, nxt;
    desc_t         d;
    logic          go_on;

    assign go_on = run_en && !halt && !d.halt_after;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= W_IDLE;
            k   <= '0;
            cur <= '0;
            nxt <= '0;
            d   <= '0;
        end else begin
            case (st)
                W_IDLE: begin
                    if (run_en && !halt) begin
                        k <= '0;
                        if (have_last) begin
                            st <= W_LINK_RQ;
                        end else begin
                            cur <= base_addr;
                            st  <= W_FETCH_RQ;
                        end
                    end
                end
                W_LINK_RQ: st <= W_LINK_RX;
                W_LINK_RX: begin
                    cur <= mem_rdata[AW-1:0];
                    st  <= W_FETCH_RQ;
                end
                W_FETCH_RQ: st <= W_FETCH_RX;
                W_FETCH_RX: begin
                    case (k)
                        3'd0: d.stat <= mem_rdata;
                        3'd1: begin
                            d.halt_after <= mem_rdata[CTRL_HALT_BIT];
                            d.eop        <= mem_rdata[CTRL_EOP_BIT];
                        end
                        3'd2:    d.src <= mem_rdata;
                        3'd3:    d.dst <= mem_rdata;
                        3'd4:    d.len <= mem_rdata;
                        default: nxt   <= mem_rdata[AW-1:0];
                    endcase
                    if (k == 3'd0 && !mem_rdata[STAT_BUSY_BIT])
                        st <= W_IDLE;
                    else if (k == K_LAST)
                        st <= W_LAUNCH;
                    else begin
                        k  <= k + 3'd1;
                        st <= W_FETCH_RQ;
                    end
                end
                W_LAUNCH: st <= W_WAIT;
                W_WAIT: if (xfer_done) st <= W_WB;
                W_WB: begin
                    if (go_on) begin
                        cur <= nxt;
                        k   <= '0;
                        st  <= W_FETCH_RQ;
                    end else begin
                        st <= W_IDLE;
                    end
                end
                default: st <= W_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req   = (st == W_LINK_RQ) || (st == W_FETCH_RQ) || (st == W_WB);
        mem_we    = (st == W_WB);
        case (st)
            W_LINK_RQ: mem_addr = base_addr + AW'(OFF_NEXT);
            W_WB:      mem_addr = cur + AW'(OFF_STAT);
            default:   mem_addr = cur + AW'(fetch_off(k));
        endcase
        mem_wdata = d.stat;
        mem_wdata[STAT_BUSY_BIT] = 1'b0;
    end

    assign xfer_start = (st == W_LAUNCH);
    assign xfer_src   = d.src;
    assign xfer_dst   = d.dst;
    assign xfer_len   = d.len;
    assign busy       = (st != W_IDLE);
    assign done_evt   = (st == W_WB);
    assign done_addr  = cur;
    assign chain_end  = (st == W_WB) && d.halt_after;
    assign pkt_done   = (st == W_WB) && d.eop;

endmodule

// File: rtl/sgd_engine.sv
module sgd_engine
    import sgd_pkg::*;
#(
    parameter int unsigned AW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              xfer_start,
    output logic [WORD_W-1:0] xfer_src,
    output logic [WORD_W-1:0] xfer_dst,
    output logic [WORD_W-1:0] xfer_len,
    input  logic              xfer_done,
    output logic              pkt_done
);

    logic          run_en, halt_w, have_last_w, eng_busy, done_evt, chain_end;
    logic [AW-1:0] base_w, done_addr;

    sgd_regs #(.AW(AW)) u_regs (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .run_en(run_en), .halt(halt_w), .base_addr(base_w), .have_last(have_last_w),
        .eng_busy(eng_busy), .done_evt(done_evt), .done_addr(done_addr), .chain_end(chain_end)
    );

    sgd_walker #(.AW(AW)) u_walk (
        .clk(clk), .rst(rst),
        .run_en(run_en), .halt(halt_w), .base_addr(base_w), .have_last(have_last_w),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .xfer_start(xfer_start), .xfer_src(xfer_src), .xfer_dst(xfer_dst),
        .xfer_len(xfer_len), .xfer_done(xfer_done),
        .busy(eng_busy), .done_evt(done_evt), .done_addr(done_addr),
        .chain_end(chain_end), .pkt_done(pkt_done)
    );

endmodule

// File: rtl/sgd_engine_chk.sv
module sgd_engine_chk #(
    parameter int unsigned AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          xfer_start,
    input logic          mem_req,
    input logic          mem_we,
    input logic [31:0]   mem_wdata,
    input logic          pkt_done,
    input logic          busy,
    input logic          halt,
    input logic          chain_end,
    input logic          done_evt,
    input logic [AW-1:0] done_addr,
    input logic [AW-1:0] daddr
);

    // R2
    start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_start |=> !xfer_start);

    // R4
    wb_busy_clear_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_req && !mem_wdata[31]));

    // R12
    pkt_on_wb_chk: assert property (@(posedge clk) disable iff (rst)
        pkt_done |-> mem_we);

    // R5
    halt_after_end_chk: assert property (@(posedge clk) disable iff (rst)
        chain_end |=> halt);

    // R8
    busy_on_start_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_start |-> busy);

    // R13
    halted_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (halt && !busy) |=> (!mem_req && !xfer_start));

    // R6
    daddr_track_chk: assert property (@(posedge clk) disable iff (rst)
        done_evt |=> (daddr == $past(done_addr)));

endmodule

bind sgd_engine sgd_engine_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst(rst), .xfer_start(xfer_start), .mem_req(mem_req),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .pkt_done(pkt_done),
    .busy(eng_busy), .halt(halt_w), .chain_end(chain_end),
    .done_evt(done_evt), .done_addr(done_addr), .daddr(base_w)
);

// File: tb/sim_sgd_engine.sv
`timescale 1ns/1ps
module sim_sgd_engine;

    localparam int AW = 16;
    localparam int WATCHDOG = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        xfer_start;
    logic [31:0] xfer_src, xfer_dst, xfer_len;
    logic        xfer_done = 1'b0;
    logic        pkt_done;

    always #2 clk = ~clk;

    sgd_engine #(.AW(AW)) u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .xfer_start(xfer_start), .xfer_src(xfer_src), .xfer_dst(xfer_dst),
        .xfer_len(xfer_len), .xfer_done(xfer_done), .pkt_done(pkt_done)
    );

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;
    int mem_req_cnt = 0;
    int pkt_cnt = 0;
    int mover_lat = 30;
    int mover_cnt = 0;
    logic last_eop = 1'b0;
    logic [31:0] mem [0:255];

    int q_src[$];
    int q_dst[$];
    int q_len[$];
    int q_eop[$];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // behavioural memory: read data one cycle after the request
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[7:0]];
        end
    end

    // behavioural mover
    always @(posedge clk) begin
        xfer_done <= 1'b0;
        if (xfer_start) mover_cnt <= mover_lat;
        else if (mover_cnt != 0) begin
            mover_cnt <= mover_cnt - 1;
            if (mover_cnt == 1) xfer_done <= 1'b1;
        end
    end

    // per-clock comparison against the expected transfer queue
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_req) mem_req_cnt++;
            if (xfer_start) begin
                if (q_src.size() == 0) begin
                    chk("R10 unexpected launch", xfer_src, 32'hFFFF_FFFF);
                end else begin
                    chk("R2 src", xfer_src, q_src[0]);
                    chk("R2 dst", xfer_dst, q_dst[0]);
                    chk("R3 len/order", xfer_len, q_len[0]);
                    last_eop = q_eop[0][0];
                    void'(q_src.pop_front()); void'(q_dst.pop_front());
                    void'(q_len.pop_front()); void'(q_eop.pop_front());
                end
            end
            if (mem_we) begin
                chk("R12 pkt strobe", {31'd0, pkt_done}, {31'd0, last_eop});
                chk("R4 wb busy bit", {31'd0, mem_wdata[31]}, 32'd0);
            end else if (pkt_done) begin
                chk("R12 stray strobe", 32'd1, 32'd0);
            end
            if (pkt_done) pkt_cnt++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == WATCHDOG) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected fewer cycles", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic wr_reg(input logic [2:0] sel, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = sel; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] sel, output logic [31:0] v);
        @(negedge clk);
        reg_addr = sel;
        #0.5 v = reg_rdata;
    endtask

    task automatic mk_desc(input int a, input logic [31:0] ctrl, input int src,
                           input int len, input logic [31:0] stat, input int nxt);
        mem[a+0] = ctrl;
        mem[a+1] = src;
        mem[a+2] = src + 32'h1000;
        mem[a+3] = len;
        mem[a+4] = stat;
        for (int i = 5; i < 9; i++) mem[a+i] = 32'hA5A5_0000 + i;
        mem[a+9] = nxt;
    endtask

    task automatic expect_xfer(input int src, input int len, input int eop);
        q_src.push_back(src); q_dst.push_back(src + 32'h1000);
        q_len.push_back(len); q_eop.push_back(eop);
    endtask

    logic [31:0] rv;

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        // ring: 16 -> 32 -> 48 -> 64 -> 16
        mk_desc(16, 32'h0000_0000, 32'h100, 64, 32'h8000_0005, 32);
        mk_desc(32, 32'h4000_0000, 32'h110, 96, 32'h8000_0006, 48);
        mk_desc(48, 32'hC000_0000, 32'h120, 128, 32'h8000_0007, 64);
        mk_desc(64, 32'h4000_0000, 32'h130, 160, 32'h0000_0000, 16);
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        rd_reg(3'd0, rv); chk("R1 enable", rv, 32'h0);
        rd_reg(3'd1, rv); chk("R1 halt", rv, 32'h8000_0000);
        rd_reg(3'd2, rv); chk("R1 daddr", rv, 32'h0);
        rd_reg(3'd3, rv); chk("R1 events", rv, 32'h0);
        rd_reg(3'd4, rv); chk("R1 status", rv, 32'h0);
        chk("R1 no launch", {31'd0, xfer_start}, 32'd0);

        // R13 enable with halt still set: no memory traffic
        wr_reg(3'd2, 32'd16);
        wr_reg(3'd0, 32'h8000_0000);
        repeat (20) @(posedge clk);
        chk("R13 quiet while halted", mem_req_cnt, 0);

        // main chain: halts after the third descriptor
        expect_xfer(32'h100, 64, 0);
        expect_xfer(32'h110, 96, 1);
        expect_xfer(32'h120, 128, 1);
        wr_reg(3'd1, 32'h0);
        wait (q_src.size() == 2);
        repeat (3) @(posedge clk);
        rd_reg(3'd4, rv); chk("R8 busy mid-chain", rv, 32'h8000_0000);
        wait (q_src.size() == 0);
        repeat (60) @(posedge clk);
        rd_reg(3'd1, rv); chk("R5 halt set by descriptor", rv, 32'h8000_0000);
        rd_reg(3'd3, rv); chk("R5 chain-end event", rv, 32'h2);
        rd_reg(3'd2, rv); chk("R6 last completed", rv, 32'd48);
        rd_reg(3'd4, rv); chk("R8 idle", rv, 32'h0);
        chk("R4 d0 status", mem[20], 32'h0000_0005);
        chk("R4 d1 status", mem[36], 32'h0000_0006);
        chk("R4 d2 status", mem[52], 32'h0000_0007);
        chk("R5 d3 untouched", mem[68], 32'h0);
        chk("R12 packet count", pkt_cnt, 2);

        // R7 write-one-to-clear
        wr_reg(3'd3, 32'h0); rd_reg(3'd3, rv); chk("R7 write 0 keeps", rv, 32'h2);
        wr_reg(3'd3, 32'h1); rd_reg(3'd3, rv); chk("R7 other bit keeps", rv, 32'h2);
        wr_reg(3'd3, 32'h2); rd_reg(3'd3, rv); chk("R7 write 1 clears", rv, 32'h0);

        // resume: follows link of 48 to 64, then refuses 16 (busy clear)
        mem[68] = 32'h8000_0000;
        expect_xfer(32'h130, 160, 1);
        wr_reg(3'd1, 32'h0);
        repeat (200) @(posedge clk);
        chk("R9 resumed via link", q_src.size(), 0);
        rd_reg(3'd2, rv); chk("R9 daddr after resume", rv, 32'd64);
        chk("R10 stale d0 kept", mem[20], 32'h0000_0005);
        wr_reg(3'd0, 32'h0);
        repeat (20) @(posedge clk);
        rd_reg(3'd3, rv); chk("R11 ack while idle", rv, 32'h1);
        rd_reg(3'd4, rv); chk("R8 idle after disable", rv, 32'h0);
        wr_reg(3'd3, 32'h1);

        // graceful disable during a long transfer
        mover_lat = 60;
        mem[20] = 32'h8000_0011;
        mem[36] = 32'h8000_0012;
        expect_xfer(32'h100, 64, 0);
        wr_reg(3'd0, 32'h8000_0000);
        wait (q_src.size() == 0);
        repeat (5) @(posedge clk);
        wr_reg(3'd0, 32'h0);
        rd_reg(3'd3, rv); chk("R11 no ack before completion", rv, 32'h0);
        repeat (200) @(posedge clk);
        rd_reg(3'd3, rv); chk("R11 ack after completion", rv, 32'h1);
        rd_reg(3'd2, rv); chk("R11 current finished", rv, 32'd16);
        chk("R11 d0 written back", mem[20], 32'h0000_0011);
        chk("R11 d1 not started", mem[36], 32'h8000_0012);
        wr_reg(3'd3, 32'h1);

        // R9 software-written address overrides the remembered position
        mover_lat = 10;
        mem[32] = 32'hC000_0000;
        expect_xfer(32'h110, 96, 1);
        wr_reg(3'd2, 32'd32);
        wr_reg(3'd0, 32'h8000_0000);
        repeat (200) @(posedge clk);
        chk("R9 started at written address", q_src.size(), 0);
        rd_reg(3'd2, rv); chk("R9 daddr", rv, 32'd32);
        rd_reg(3'd3, rv); chk("R5 end event again", rv, 32'h2);
        chk("R4 d1 status", mem[36], 32'h0000_0012);

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule